// File: doc/BRIEF.md
# Multi-format serial audio port

This block receives and transmits stereo PCM over a three-wire serial link: an externally supplied bit clock, a word sync line, and one data line in each direction. Incoming serial bits are collected into 16-bit left and right samples that appear on parallel outputs with a one-cycle valid strobe. Two parallel 16-bit transmit samples are serialised onto the outgoing data line in the same frame layout.

A 2-bit format selector picks the frame layout while the link runs. Three layouts use 24-bit slots (48 bit clocks per frame) with the data word pushed against the end of the slot, carrying 16, 18 or 20 data bits. The fourth layout uses 32-bit slots (64 bit clocks per frame) with a 16-bit word that starts one bit clock after the sync edge. Data always travels most significant bit first. The sync line is high for the left slot and low for the right slot.

The whole block runs on the bit clock. The asynchronous reset is released through a two-stage synchroniser on that clock.

Top module: `snd_serial_port`

## Requirements
- R1: While reset is asserted, and after its release until the first valid frame, rx_left and rx_right are 0 and rx_valid is 0. sdo is 0 during reset.
- R2: With fmt_sel = 2'b00, each slot is 24 bits long. Slot positions 8 to 23 carry the 16-bit word MSB first on both sdi and sdo.
- R3: With fmt_sel = 2'b01, positions 6 to 23 carry an 18-bit word. The received sample is the word's upper 16 bits (positions 6 to 21). sdo sends the 16-bit transmit sample at positions 6 to 21 and 0 at positions 22 and 23.
- R4: With fmt_sel = 2'b10, positions 4 to 23 carry a 20-bit word. The received sample is taken from positions 4 to 19. sdo sends the sample at positions 4 to 19 and 0 at positions 20 to 23.
- R5: With fmt_sel = 2'b11, each slot is 32 bits long. The 16-bit word sits at positions 1 to 16 MSB first, so position 0 is a one-bit delay after the sync edge.
- R6: sdi and sync_in are sampled on the rising edge of bclk, and sdo changes only on the falling edge. Position 0 of a slot is the first rising edge at which sync_in differs from its previous sampled level. A high level marks the left slot and a low level marks the right slot.
- R7: sdi bits outside the data positions of the selected format do not affect the received samples. sdo is 0 at every position outside the transmit window.
- R8: rx_valid is a single-cycle pulse. It is raised after the rising edge that samples the last received data bit of a right slot, but only if the left slot just before it was captured in full. rx_left and rx_right update together at that moment.
- R9: The transmit sample for a slot is taken from tx_left or tx_right at position 0 of that slot. Later changes to the input during the slot do not alter sdo.
- R10: fmt_sel may change between frames, and the next frame follows the new layout without a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Frame format select (00, 01, 10 short slots; 11 long slot) |
| sync_in | input | 1 | Word sync, high for left slot, low for right slot |
| sdi | input | 1 | Serial data in, MSB first |
| tx_left | input | 16 | Left sample to transmit |
| tx_right | input | 16 | Right sample to transmit |
| sdo | output | 1 | Serial data out, changes on falling bclk |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe when a full frame has been received |

## Verification
A wrong slot position or window start shows up in the very next frame. The received samples come out shifted by whole bits, and sdo carries data in the padding positions or zero in data positions. Both are visible within one slot of 24 or 32 bit clocks. A lost or duplicated left-seen state shows as a missing or extra rx_valid pulse, or a pulse at the wrong bit, in the frame where it happens. A latch taken at the wrong moment shows when the transmit input changes in the middle of a slot.

// File: rtl/snd_port_pkg.sv
package snd_port_pkg;

  localparam int SHORT_SLOT   = 24;
  localparam int LONG_SLOT    = 32;
  localparam int DEF_SAMPLE_W = 16;
  localparam int POS_W        = $clog2(LONG_SLOT);

  typedef enum logic [1:0] {
    FMT_R16 = 2'b00,
    FMT_R18 = 2'b01,
    FMT_R20 = 2'b10,
    FMT_D64 = 2'b11
  } fmt_e;

  // First slot position that carries the kept sample bits.
  function automatic logic [POS_W-1:0] win_first(fmt_e f, int sample_w);
    int d;
    case (f)
      FMT_R16: d = SHORT_SLOT - sample_w;
      FMT_R18: d = SHORT_SLOT - (sample_w + 2);
      FMT_R20: d = SHORT_SLOT - (sample_w + 4);
      default: d = 1;
    endcase
    return POS_W'(d);
  endfunction

endpackage

// File: rtl/spp_slot_track.sv
module spp_slot_track #(
  parameter int POS_W = snd_port_pkg::POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic             new_slot,
  output logic [POS_W-1:0] pos_now,
  output logic             chan_now,
  output logic [POS_W-1:0] pos_q,
  output logic             chan_q
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  always_comb begin
    new_slot = (sync_in != chan_q);
    chan_now = sync_in;
    if (new_slot)             pos_now = '0;
    else if (pos_q == POS_MAX) pos_now = POS_MAX;
    else                      pos_now = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_MAX;
      chan_q <= 1'b0;
    end else begin
      pos_q  <= pos_now;
      chan_q <= chan_now;
    end
  end

  // R6
  slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> pos_q == '0);

endmodule

// File: rtl/spp_rx.sv
module spp_rx #(
  parameter int SAMPLE_W = snd_port_pkg::DEF_SAMPLE_W,
  parameter int POS_W    = snd_port_pkg::POS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdi,
  input  logic [POS_W-1:0]    pos_now,
  input  logic                chan_now,
  input  logic [POS_W-1:0]    win_lo,
  input  logic [POS_W-1:0]    win_hi,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  logic [SAMPLE_W-1:0] shift_q, shift_d, hold_q, hold_d, left_d, right_d, captured;
  logic                lok_q, lok_d, valid_d, in_win, at_end;

  always_comb begin
    in_win   = (pos_now >= win_lo) && (pos_now <= win_hi);
    at_end   = in_win && (pos_now == win_hi);
    captured = {shift_q[SAMPLE_W-2:0], sdi};
    shift_d  = in_win ? captured : shift_q;
    hold_d   = hold_q;
    lok_d    = lok_q;
    left_d   = rx_left;
    right_d  = rx_right;
    valid_d  = 1'b0;
    if (at_end && chan_now) begin
      hold_d = captured;
      lok_d  = 1'b1;
    end else if (at_end && !chan_now && lok_q) begin
      left_d  = hold_q;
      right_d = captured;
      valid_d = 1'b1;
      lok_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      hold_q   <= '0;
      lok_q    <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      hold_q   <= hold_d;
      lok_q    <= lok_d;
      rx_left  <= left_d;
      rx_right <= right_d;
      rx_valid <= valid_d;
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !lok_q);

endmodule

// File: rtl/spp_tx.sv
module spp_tx #(
  parameter int SAMPLE_W = snd_port_pkg::DEF_SAMPLE_W,
  parameter int POS_W    = snd_port_pkg::POS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                new_slot,
  input  logic                chan_now,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic [POS_W-1:0]    pos_q,
  input  logic [POS_W-1:0]    win_lo,
  input  logic [POS_W-1:0]    win_hi,
  output logic                sdo
);
  localparam int               IDX_W   = $clog2(SAMPLE_W);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [SAMPLE_W-1:0] word_q, word_d;
  logic [POS_W-1:0]    pos_next, diff;
  logic                sdo_d;

  always_comb begin
    word_d = word_q;
    if (new_slot) word_d = chan_now ? tx_left : tx_right;
  end

  always_comb begin
    pos_next = (pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1;
    diff     = win_hi - pos_next;
    sdo_d    = 1'b0;
    if (pos_next >= win_lo && pos_next <= win_hi)
      sdo_d = word_q[diff[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else        sdo <= sdo_d;
  end

  // R7
  pad_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (pos_q < win_lo || pos_q > win_hi) |-> !sdo);

endmodule

// File: rtl/snd_serial_port.sv
module snd_serial_port #(
  parameter int SAMPLE_W = snd_port_pkg::DEF_SAMPLE_W,
  parameter int POS_W    = snd_port_pkg::POS_W
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                sync_in,
  input  logic                sdi,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                sdo,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);
  import snd_port_pkg::*;

  logic [1:0]       rst_ff;
  logic             rst_sync_n, new_slot, chan_now, chan_q;
  logic [POS_W-1:0] pos_now, pos_q, win_lo, win_hi;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  assign win_lo = win_first(fmt_e'(fmt_sel), SAMPLE_W);
  assign win_hi = win_lo + POS_W'(SAMPLE_W - 1);

  spp_slot_track #(.POS_W(POS_W)) i_track (
    .clk(bclk), .rst_n(rst_sync_n), .sync_in(sync_in), .new_slot(new_slot),
    .pos_now(pos_now), .chan_now(chan_now), .pos_q(pos_q), .chan_q(chan_q));

  spp_rx #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) i_rx (
    .clk(bclk), .rst_n(rst_sync_n), .sdi(sdi), .pos_now(pos_now),
    .chan_now(chan_now), .win_lo(win_lo), .win_hi(win_hi),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  spp_tx #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) i_tx (
    .clk(bclk), .rst_n(rst_sync_n), .new_slot(new_slot), .chan_now(chan_now),
    .tx_left(tx_left), .tx_right(tx_right), .pos_q(pos_q),
    .win_lo(win_lo), .win_hi(win_hi), .sdo(sdo));

  // R8
  valid_in_right_chk: assert property (@(posedge bclk) disable iff (!rst_sync_n)
    rx_valid |-> !chan_q);

endmodule

// File: tb/test_snd_serial_port.sv
module test_snd_serial_port;
  logic        bclk = 1'b0;
  logic        rst_n, sync_in, sdi, sdo, rx_valid;
  logic [1:0]  fmt_sel;
  logic [15:0] tx_left, tx_right, rx_left, rx_right;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 bclk = ~bclk;

  snd_serial_port i_snd_serial_port (
    .bclk(bclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_in(sync_in), .sdi(sdi),
    .tx_left(tx_left), .tx_right(tx_right), .sdo(sdo),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  // {fmt, left word(20), right word(20), tx left, tx right}
  localparam logic [73:0] VECS [0:5] = '{
    {2'b00, 20'h0A5C3, 20'h0F00F, 16'h8001, 16'h7FFE},
    {2'b01, 20'h2B3C4, 20'h1D00B, 16'hC3A5, 16'h0F0F},
    {2'b10, 20'hFEDCB, 20'h13579, 16'hFFFF, 16'h0001},
    {2'b11, 20'h01234, 20'h0ABCD, 16'h1357, 16'hFFFE},
    {2'b00, 20'h0FFFF, 20'h00000, 16'h0000, 16'hFFFF},
    {2'b10, 20'h0000F, 20'hFFFF0, 16'hA55A, 16'h5AA5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_len(input int f);  return (f == 3) ? 32 : 24; endfunction
  function automatic int data_w(input int f);    return (f == 1) ? 18 : (f == 2) ? 20 : 16; endfunction
  function automatic int first_pos(input int f); return (f == 3) ? 1 : 24 - data_w(f); endfunction

  function automatic logic in_bit(input int f, input logic [19:0] w, input int p);
    int s = first_pos(f), dw = data_w(f);
    if (p >= s && p < s + dw) return w[dw - 1 - (p - s)];
    return 1'b1;  // padding driven high, must be ignored
  endfunction

  function automatic logic [15:0] exp_rx(input int f, input logic [19:0] w);
    return w[data_w(f) - 1 -: 16];
  endfunction

  task automatic run_frame(input int f, input logic [19:0] lw, input logic [19:0] rw,
                           input logic [15:0] tl, input logic [15:0] tr,
                           input bit mid_change, input string req);
    int L = slot_len(f), s = first_pos(f);
    int vcnt = 0, vpos = -1, vch = -1;
    int bad_l = 0, bad_r = 0;
    logic [15:0] cap_l = '0, cap_r = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < L; p++) begin
        logic [15:0] tw;
        logic eb;
        @(negedge bclk); #1;
        if (ch == 0 && p == 0) begin
          fmt_sel = 2'(f); tx_left = tl; tx_right = tr;
        end
        if (mid_change && ch == 0 && p == 3) tx_left = ~tl;
        if (mid_change && ch == 1 && p == 3) tx_right = ~tr;
        sync_in = (ch == 0);
        sdi = in_bit(f, (ch == 0) ? lw : rw, p);
        tw = (ch == 0) ? tl : tr;
        eb = (p >= s && p < s + 16) ? tw[15 - (p - s)] : 1'b0;
        if (sdo !== eb) begin
          if (ch == 0) bad_l++; else bad_r++;
        end
        @(posedge bclk); #1;
        if (rx_valid) begin
          vcnt++; vpos = p; vch = ch; cap_l = rx_left; cap_r = rx_right;
        end
      end
    end
    check(vcnt == 1, "R8", "valid pulses per frame", vcnt, 1);
    check(vch == 1 && vpos == s + 15, "R8", "valid bit position", vpos, s + 15);
    check(cap_l == exp_rx(f, lw), req, "rx_left", cap_l, exp_rx(f, lw));
    check(cap_r == exp_rx(f, rw), req, "rx_right", cap_r, exp_rx(f, rw));
    check(bad_l == 0, req, "sdo left slot mismatches (R7 R9)", bad_l, 0);
    check(bad_r == 0, req, "sdo right slot mismatches (R7 R9)", bad_r, 0);
    tx_left = tl; tx_right = tr;
  endtask

  function automatic string req_of(input int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; sdi = 1'b0; fmt_sel = 2'b00;
    tx_left = 16'hFFFF; tx_right = 16'hFFFF;
    repeat (3) @(negedge bclk);
    #1;
    // R1 reset state
    check(rx_left == 0 && rx_right == 0, "R1", "samples in reset", {rx_left, rx_right}, 0);
    check(rx_valid == 0, "R1", "valid in reset", rx_valid, 0);
    check(sdo == 0, "R1", "sdo in reset", sdo, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);

    // R8: short left slot followed by a full right slot gives no frame
    begin
      int vc = 0;
      for (int p = 0; p < 27; p++) begin
        @(negedge bclk); #1;
        sync_in = (p < 3); sdi = p[0];
        @(posedge bclk); #1;
        if (rx_valid) vc++;
      end
      check(vc == 0, "R8", "valid without full left slot", vc, 0);
      check(rx_left == 0 && rx_right == 0, "R1", "samples held after release", {rx_left, rx_right}, 0);
    end

    // Table walk; consecutive entries change the format (R10), padding high (R7)
    for (int i = 0; i < 6; i++) begin
      logic [73:0] v = VECS[i];
      run_frame(int'(v[73:72]), v[71:52], v[51:32], v[31:16], v[15:0], 1'b0,
                req_of(int'(v[73:72])));
    end

    // R9: transmit inputs change inside the slot; R10 format swap back
    run_frame(3, 20'h0C0DE, 20'h0BEEF, 16'h6C3A, 16'h9135, 1'b1, "R9");
    run_frame(1, 20'h3FFFF, 20'h00003, 16'h8421, 16'h1248, 1'b1, "R9");

    // R6: sync held low for a long stretch; no new frame, output stays padding
    begin
      int vc = 0, hi = 0;
      for (int p = 0; p < 40; p++) begin
        @(negedge bclk); #1;
        sync_in = 1'b0; sdi = 1'b1;
        if (p > 1 && sdo !== 1'b0) hi++;
        @(posedge bclk); #1;
        if (rx_valid) vc++;
      end
      check(vc == 0, "R6", "valid with no sync edge", vc, 0);
      check(hi == 0, "R6", "sdo with no sync edge", hi, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bclk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule